// File: doc/BRIEF.md
# Receive Software Flow Character Detector

This block sits behind a UART receiver and looks at every completed 8-bit character. Four programmable character registers hold two "resume" codes (A and B) and two "pause" codes (A and B). Depending on a 4-bit flow-mode field, a received character that matches a pause code sets a transmit-suspend output, and one that matches a resume code clears it. Matched flow characters are consumed. Every other character is forwarded to the receive FIFO through a write strobe and data bus. In pair mode, the A code followed directly by the B code forms one pause or resume event.

When the flow-mode field is entirely zero and special detection is enabled, the block does no flow control. It forwards every character and raises a sticky interrupt flag whenever a character equals pause code B. Software clears that flag by pulsing a status-read input. Characters arrive as a one-cycle strobe. Successive strobes are separated by at least one idle cycle, which is the normal case at serial bit rates.

The controller has four states, and each transition is listed below. IDLE waits for a character. IDLE goes to ON_HALF or OFF_HALF when pair mode sees resume A or pause A. ON_HALF or OFF_HALF goes back to IDLE when the matching B code arrives, which completes the event. A half state goes to FLUSH when the next character breaks the pair and cannot start a new one. A half state moves to the other half state, or stays where it is, when the breaking character is itself an A code. A half state goes back to IDLE when the mode leaves pair mode. FLUSH goes back to IDLE after one cycle, in which it writes the held character.

Top module: `rxfc_detect`

## Requirements
- R1: After reset, `tx_hold`, `spec_flag` and `fifo_we` are 0.
- R2: With `flow_mode[1:0]`=00 and special detection inactive, every character is written unchanged, with `fifo_we` high in the cycle after its strobe. `tx_hold` is forced to 0 one cycle after the receive flow bits become 00.
- R3: With `flow_mode[1:0]`=10 (single, A codes), a character equal to `pause_a` sets `tx_hold` and one equal to `resume_a` clears it. Neither is written to the FIFO, and all other characters are written. If both registers hold the same value, pause wins. Register bit 0 is compared with character bit 0.
- R4: With `flow_mode[1:0]`=01 (single, B codes), the same rule uses `pause_b` and `resume_b`. A-code characters are written as data in this mode.
- R5: With `flow_mode[1:0]`=11 (pair), `pause_a` followed by `pause_b` sets `tx_hold`, and `resume_a` followed by `resume_b` clears it. Neither character of a completed pair is written.
- R6: In pair mode, when the character after a held A code does not complete the pair, the held character is written first. The breaking character is then re-examined. If it is an A code it is held as a new first half. Otherwise it is written one cycle later, two cycles after its strobe. In either case `tx_hold` is unchanged.
- R7: With `spec_en`=1 and `flow_mode`=0000, every character is written. A character equal to `pause_b` sets `spec_flag` in the same cycle as its write.
- R8: `spec_flag` stays set until a `stat_rd` pulse clears it. A match in the same cycle as `stat_rd` leaves it set.
- R9: Special detection is inactive whenever `flow_mode` is non-zero. A `pause_b` character then raises no flag.
- R10: `flow_mode[3:2]` (the transmit-side selection) has no effect on receive detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is ready |
| rx_byte | input | 8 | Received character |
| resume_a | input | 8 | Resume code A (single or first of pair) |
| resume_b | input | 8 | Resume code B (single or second of pair) |
| pause_a | input | 8 | Pause code A (single or first of pair) |
| pause_b | input | 8 | Pause code B; also the special-detect code |
| flow_mode | input | 4 | [3:2] transmit side (ignored here); [1:0] receive compare: 00 off, 01 B codes, 10 A codes, 11 pairs |
| spec_en | input | 1 | Special-character detect enable |
| stat_rd | input | 1 | Interrupt status read pulse; clears `spec_flag` |
| tx_hold | output | 1 | Transmitter suspend request |
| spec_flag | output | 1 | Special-character interrupt flag |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Character to write |

## Verification
The strobe is sampled at one edge, and every registered result appears after that edge. `tx_hold`, `spec_flag` and the write of a character that needs no holding all show up one cycle after the strobe. A write that comes from a broken pair is the held character in that same cycle, followed by the breaking character one cycle later. The bench drives on falling edges and samples on falling edges. A monitor compares each `fifo_we` pulse against a queue of expected bytes kept in order, so a write that lands one or two cycles after its strobe is accepted. A write that is missing, extra or out of order is reported. Flag and hold checks are made only after the driver has let at least two edges pass since the last strobe.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ON_HALF  = 2'd1,
        ST_OFF_HALF = 2'd2,
        ST_FLUSH    = 2'd3
    } rxfc_state_e;

    typedef enum logic [1:0] {
        RXM_OFF   = 2'b00,
        RXM_SET_B = 2'b01,
        RXM_SET_A = 2'b10,
        RXM_PAIR  = 2'b11
    } rxfc_mode_e;

    localparam int HIT_ON_A  = 0;
    localparam int HIT_ON_B  = 1;
    localparam int HIT_OFF_A = 2;
    localparam int HIT_OFF_B = 3;
    localparam int NUM_CODES = 4;
endpackage

// File: rtl/rxfc_match.sv
module rxfc_match #(
    parameter int CW    = 8,
    parameter int NCODE = 4
) (
    input  logic [CW-1:0]            ch,
    input  logic [NCODE-1:0][CW-1:0] codes,
    output logic [NCODE-1:0]         hit
);
    for (genvar gi = 0; gi < NCODE; gi++) begin : g_cmp
        assign hit[gi] = (ch == codes[gi]);
    end
endmodule

// File: rtl/rxfc_seq_fsm.sv
module rxfc_seq_fsm
    import rxfc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [CW-1:0]        rx_byte,
    input  logic [NUM_CODES-1:0] hit,
    input  logic [1:0]           rx_mode,
    output logic                 tx_hold,
    output logic                 fifo_we,
    output logic [CW-1:0]        fifo_data
);
    rxfc_state_e   state_q, state_n;
    logic [CW-1:0] pend_q, pend_n;
    logic          hold_n, we_n;
    logic [CW-1:0] data_n;
    logic          second_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold   <= 1'b0;
            fifo_we   <= 1'b0;
            fifo_data <= '0;
        end else begin
            tx_hold   <= hold_n;
            fifo_we   <= we_n;
            fifo_data <= data_n;
        end
    end

    assign second_ok = (state_q == ST_OFF_HALF) ? hit[HIT_OFF_B] : hit[HIT_ON_B];

    always_comb begin
        state_n = state_q;
        pend_n  = pend_q;
        hold_n  = tx_hold;
        we_n    = 1'b0;
        data_n  = fifo_data;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_valid) begin
                    unique case (rx_mode)
                        RXM_OFF: begin
                            we_n   = 1'b1;
                            data_n = rx_byte;
                        end
                        RXM_SET_A: begin
                            if (hit[HIT_OFF_A])      hold_n = 1'b1;
                            else if (hit[HIT_ON_A])  hold_n = 1'b0;
                            else begin
                                we_n   = 1'b1;
                                data_n = rx_byte;
                            end
                        end
                        RXM_SET_B: begin
                            if (hit[HIT_OFF_B])      hold_n = 1'b1;
                            else if (hit[HIT_ON_B])  hold_n = 1'b0;
                            else begin
                                we_n   = 1'b1;
                                data_n = rx_byte;
                            end
                        end
                        RXM_PAIR: begin
                            if (hit[HIT_OFF_A]) begin
                                pend_n  = rx_byte;
                                state_n = ST_OFF_HALF;
                            end else if (hit[HIT_ON_A]) begin
                                pend_n  = rx_byte;
                                state_n = ST_ON_HALF;
                            end else begin
                                we_n   = 1'b1;
                                data_n = rx_byte;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_ON_HALF, ST_OFF_HALF: begin
                if (rx_mode != RXM_PAIR) begin
                    we_n    = 1'b1;
                    data_n  = pend_q;
                    state_n = ST_IDLE;
                    if (rx_valid) begin
                        pend_n  = rx_byte;
                        state_n = ST_FLUSH;
                    end
                end else if (rx_valid) begin
                    if (second_ok) begin
                        hold_n  = (state_q == ST_OFF_HALF);
                        state_n = ST_IDLE;
                    end else begin
                        we_n   = 1'b1;
                        data_n = pend_q;
                        pend_n = rx_byte;
                        if (hit[HIT_OFF_A])     state_n = ST_OFF_HALF;
                        else if (hit[HIT_ON_A]) state_n = ST_ON_HALF;
                        else                    state_n = ST_FLUSH;
                    end
                end
            end
            ST_FLUSH: begin
                we_n    = 1'b1;
                data_n  = pend_q;
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
        if (rx_mode == RXM_OFF) hold_n = 1'b0;
    end

    AST_FLUSH_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> fifo_we); // R6
    AST_HOLD_RISE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_hold) |-> !fifo_we); // R3
    AST_HOLD_RISE_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_hold) |-> $past(rx_valid)); // R5
    AST_HOLD_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == RXM_OFF) |=> !tx_hold); // R2
endmodule

// File: rtl/rxfc_spec_flag.sv
module rxfc_spec_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic spec_act,
    input  logic code_hit,
    input  logic clr,
    output logic flag
);
    logic set_now;
    assign set_now = rx_valid && spec_act && code_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_now) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R8
    AST_FLAG_ONLY_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(spec_act && rx_valid)); // R9
endmodule

// File: rtl/rxfc_detect.sv
module rxfc_detect
    import rxfc_pkg::*;
#(
    parameter int CW = 8,
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_byte,
    input  logic [CW-1:0] resume_a,
    input  logic [CW-1:0] resume_b,
    input  logic [CW-1:0] pause_a,
    input  logic [CW-1:0] pause_b,
    input  logic [MW-1:0] flow_mode,
    input  logic          spec_en,
    input  logic          stat_rd,
    output logic          tx_hold,
    output logic          spec_flag,
    output logic          fifo_we,
    output logic [CW-1:0] fifo_data
);
    logic [NUM_CODES-1:0][CW-1:0] codes;
    logic [NUM_CODES-1:0]         hit;
    logic                         spec_act;

    assign codes[HIT_ON_A]  = resume_a;
    assign codes[HIT_ON_B]  = resume_b;
    assign codes[HIT_OFF_A] = pause_a;
    assign codes[HIT_OFF_B] = pause_b;
    assign spec_act = spec_en && (flow_mode == '0);

    rxfc_match #(.CW(CW), .NCODE(NUM_CODES)) u_match (
        .ch    (rx_byte),
        .codes (codes),
        .hit   (hit)
    );

    rxfc_seq_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .hit       (hit),
        .rx_mode   (flow_mode[1:0]),
        .tx_hold   (tx_hold),
        .fifo_we   (fifo_we),
        .fifo_data (fifo_data)
    );

    rxfc_spec_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .spec_act (spec_act),
        .code_hit (hit[HIT_OFF_B]),
        .clr      (stat_rd),
        .flag     (spec_flag)
    );

    AST_SPECIAL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && spec_act) |=> (fifo_we && fifo_data == $past(rx_byte))); // R7
endmodule

// File: tb/rxfc_detect_tb.sv
module rxfc_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [7:0] resume_a = 8'h11, resume_b = 8'h12, pause_a = 8'h13, pause_b = 8'h14;
    logic [3:0] flow_mode = '0;
    logic       spec_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       tx_hold, spec_flag, fifo_we;
    logic [7:0] fifo_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    rxfc_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .resume_a(resume_a), .resume_b(resume_b), .pause_a(pause_a), .pause_b(pause_b),
        .flow_mode(flow_mode), .spec_en(spec_en), .stat_rd(stat_rd),
        .tx_hold(tx_hold), .spec_flag(spec_flag), .fifo_we(fifo_we), .fifo_data(fifo_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endtask

    // monitor: compares each FIFO write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && fifo_we) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL unexpected write actual %0h expected none", fifo_data);
            end else begin
                string t;
                logic [7:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, fifo_data, e);
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drained(input string req);
        chk(req, 8'(exp_q.size()), 8'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hold", tx_hold, 0);
        chk("R1 flag", spec_flag, 0);
        chk("R1 we", fifo_we, 0);

        // R2: plain pass-through, hold forced low
        flow_mode = 4'b0000;
        expect_wr(8'h11, "R2"); send(8'h11);
        expect_wr(8'h13, "R2"); send(8'h13);
        expect_wr(8'h5A, "R2"); send(8'h5A);
        drained("R2 writes");
        flow_mode = 4'b0010;
        send(8'h13);
        chk("R2 hold set first", tx_hold, 1);
        @(negedge clk); flow_mode = 4'b0000;
        @(negedge clk);
        chk("R2 hold forced low", tx_hold, 0);

        // R3: single A codes; R10 upper bits ignored
        flow_mode = 4'b0110;
        send(8'h13);
        chk("R3 R10 pause_a sets hold", tx_hold, 1);
        expect_wr(8'h41, "R3"); send(8'h41);
        chk("R3 data keeps hold", tx_hold, 1);
        send(8'h11);
        chk("R3 resume_a clears hold", tx_hold, 0);
        drained("R3 consumed");
        pause_a = 8'h20; resume_a = 8'h20;
        send(8'h20);
        chk("R3 pause priority", tx_hold, 1);
        pause_a = 8'h13; resume_a = 8'h11;
        send(8'h11);
        chk("R3 clear again", tx_hold, 0);

        // R4: single B codes
        flow_mode = 4'b0001;
        send(8'h14);
        chk("R4 pause_b sets hold", tx_hold, 1);
        expect_wr(8'h13, "R4"); send(8'h13);
        chk("R4 A code is data", tx_hold, 1);
        send(8'h12);
        chk("R4 resume_b clears hold", tx_hold, 0);
        drained("R4 writes");

        // R5: pairs
        flow_mode = 4'b1111;
        send(8'h13); send(8'h14);
        chk("R5 pause pair sets hold", tx_hold, 1);
        send(8'h11); send(8'h12);
        chk("R5 resume pair clears hold", tx_hold, 0);
        drained("R5 nothing written");

        // R6: broken pairs
        expect_wr(8'h13, "R6 held first"); expect_wr(8'h77, "R6 breaker");
        send(8'h13); send(8'h77);
        chk("R6 hold unchanged", tx_hold, 0);
        drained("R6 both written");
        send(8'h13); send(8'h14);
        chk("R6 hold set", tx_hold, 1);
        expect_wr(8'h13, "R6 held replaced");
        send(8'h13); send(8'h11); send(8'h12);
        chk("R6 breaker starts pair", tx_hold, 0);
        drained("R6 restart");

        // R7: special detect
        flow_mode = 4'b0000; spec_en = 1'b1;
        expect_wr(8'h22, "R7"); send(8'h22);
        chk("R7 no flag on other", spec_flag, 0);
        expect_wr(8'h14, "R7 match written"); send(8'h14);
        chk("R7 flag set", spec_flag, 1);
        drained("R7 writes");

        // R8: sticky flag, clear by status read
        expect_wr(8'h23, "R8"); send(8'h23);
        chk("R8 flag sticky", spec_flag, 1);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk("R8 flag cleared", spec_flag, 0);
        expect_wr(8'h14, "R8 set vs clear");
        @(negedge clk); rx_byte = 8'h14; rx_valid = 1'b1; stat_rd = 1'b1;
        @(negedge clk); rx_valid = 1'b0; stat_rd = 1'b0;
        chk("R8 set wins", spec_flag, 1);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;

        // R9: special inactive when mode nonzero
        flow_mode = 4'b0100;
        expect_wr(8'h14, "R9"); send(8'h14);
        chk("R9 no flag", spec_flag, 0);
        chk("R9 no hold", tx_hold, 0);
        drained("R9 writes");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule